// File: doc/BRIEF.md
# Strobe and Acknowledge Parallel Byte Receiver

This block accepts bytes from an external peripheral over a parallel data bus. The peripheral marks a byte as valid with an active-low strobe. The receiver answers on an acknowledge line. Two exchange styles are supported, and a configuration input picks between them.

In the single-handshake style, the receiver latches the byte as soon as it sees the strobe fall. It then raises acknowledge until the strobe returns high. In the double-handshake style, a falling strobe is a request. The receiver answers it by raising acknowledge. The peripheral then places the byte and raises the strobe, and the receiver latches the byte on that rising edge and drops acknowledge.

Each latched byte is held in a one-entry buffer and offered downstream on a valid/ready pair. While that buffer is occupied, the receiver does not acknowledge a new request, which holds the sender back. The strobe is asynchronous and is resynchronised before use. The peripheral must keep its data steady until acknowledge answers. A strobe that is withdrawn before it was answered sets a sticky error flag, which a clear input resets.

Top module: `strobe_ack_rx`

## Requirements
- R1: After reset is released, the acknowledge output, the output-valid flag and the error flag are all low.
- R2: With mode input 0 (single handshake) and the buffer empty, a high-to-low strobe transition makes acknowledge and output-valid rise together exactly three clock cycles later. The output data then equals the data bus value held since the transition.
- R3: In single-handshake mode, acknowledge stays high until the strobe returns high. It falls exactly three cycles after that low-to-high transition.
- R4: With mode input 1 (double handshake) and the buffer empty, a high-to-low strobe transition raises acknowledge exactly three cycles later, while output-valid stays low.
- R5: In double-handshake mode, the strobe's low-to-high transition latches the data bus. Three cycles later output-valid rises with that byte, and acknowledge falls in the same cycle.
- R6: While output-valid is high and ready is low, valid and the output byte hold unchanged. A cycle with valid and ready both high is a transfer, and valid is low in the next cycle.
- R7: A strobe request that arrives while the buffer holds an untaken byte leaves acknowledge low and does not overwrite the held byte. Two cycles after the transfer edge that empties the buffer, the request is answered: single mode latches the waiting byte and raises acknowledge, and double mode raises acknowledge with valid low.
- R8: A strobe that returns high while its request is still waiting for the buffer sets the error flag three cycles later. No byte is latched, acknowledge stays low, and the flag stays set until cleared, across later normal exchanges.
- R9: Asserting the clear input for one cycle drives the error flag low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_dbl_i | input | 1 | 0 selects single handshake, 1 selects double handshake; sampled when a request starts |
| stb_n_i | input | 1 | Active-low strobe from the peripheral, asynchronous |
| data_i | input | DATA_W | Parallel data bus from the peripheral |
| ack_o | output | 1 | Acknowledge to the peripheral, active high |
| out_valid_o | output | 1 | A latched byte is offered downstream |
| out_data_o | output | DATA_W | Latched byte |
| out_ready_i | input | 1 | Downstream consumer accepts the byte |
| err_clr_i | input | 1 | Clears the sticky protocol-error flag |
| proto_err_o | output | 1 | Sticky protocol-error flag |

## Verification
Every strobe-driven result (the rise or fall of acknowledge, the appearance of a latched byte, and the setting of the error flag) is due three cycles after the strobe changes. That is two synchroniser stages plus the registered state update. A transfer clears output-valid one cycle later, and a waiting request is answered two cycles after the transfer edge. The bench changes all inputs on falling clock edges and samples on the falling edge exactly that many cycles later. For the main latencies it also samples one cycle earlier, to confirm the result has not come too soon.

// File: rtl/strobe_rx_pkg.sv
package strobe_rx_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,   // strobe high, nothing pending
        HS_WAIT  = 2'd1,   // request seen, buffer still occupied
        HS_S_ACK = 2'd2,   // single mode: byte taken, ack high
        HS_D_DAT = 2'd3    // double mode: ack high, awaiting data edge
    } hs_state_e;

    typedef struct packed {
        hs_state_e state;
        logic      ack;
        logic      dbl;
        logic      err;
    } hs_regs_t;

endpackage

// File: rtl/strobe_rx_sync.sv
module strobe_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d,  prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign chain_d[i] = async_i;
        end else begin : g_next
            assign chain_d[i] = chain_q[i-1];
        end
    end

    always_comb begin
        prev_d = chain_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign fall_o = prev_q & ~chain_q[LAST];
    assign rise_o = ~prev_q & chain_q[LAST];

endmodule

// File: rtl/strobe_rx_fsm.sv
module strobe_rx_fsm
    import strobe_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_dbl_i,
    input  logic fall_i,
    input  logic rise_i,
    input  logic buf_full_i,
    input  logic err_clr_i,
    output logic capture_o,
    output logic ack_o,
    output logic dbl_o,
    output logic err_o
);
    hs_regs_t r_d, r_q;
    logic     err_set;

    always_comb begin
        r_d       = r_q;
        capture_o = 1'b0;
        err_set   = 1'b0;
        unique case (r_q.state)
            HS_IDLE: begin
                if (fall_i) begin
                    r_d.dbl = mode_dbl_i;
                    if (buf_full_i) begin
                        r_d.state = HS_WAIT;
                    end else if (mode_dbl_i) begin
                        r_d.state = HS_D_DAT;
                        r_d.ack   = 1'b1;
                    end else begin
                        capture_o = 1'b1;
                        r_d.state = HS_S_ACK;
                        r_d.ack   = 1'b1;
                    end
                end else if (rise_i) begin
                    err_set = 1'b1;
                end
            end
            HS_WAIT: begin
                if (rise_i) begin
                    err_set   = 1'b1;
                    r_d.state = HS_IDLE;
                end else if (!buf_full_i) begin
                    r_d.ack = 1'b1;
                    if (r_q.dbl) begin
                        r_d.state = HS_D_DAT;
                    end else begin
                        capture_o = 1'b1;
                        r_d.state = HS_S_ACK;
                    end
                end
            end
            HS_S_ACK: begin
                if (rise_i) begin
                    r_d.ack   = 1'b0;
                    r_d.state = HS_IDLE;
                end else if (fall_i) begin
                    err_set = 1'b1;
                end
            end
            HS_D_DAT: begin
                if (rise_i) begin
                    capture_o = 1'b1;
                    r_d.ack   = 1'b0;
                    r_d.state = HS_IDLE;
                end else if (fall_i) begin
                    err_set = 1'b1;
                end
            end
            default: r_d.state = HS_IDLE;
        endcase
        r_d.err = (r_q.err & ~err_clr_i) | err_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: HS_IDLE, ack: 1'b0, dbl: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_o = r_q.ack;
    assign dbl_o = r_q.dbl;
    assign err_o = r_q.err;

endmodule

// File: rtl/strobe_rx_obuf.sv
module strobe_rx_obuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [DATA_W-1:0] data_o
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } obuf_t;

    obuf_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (b_q.valid && ready_i) begin
            b_d.valid = 1'b0;
        end
        if (load_i) begin
            b_d.valid = 1'b1;
            b_d.data  = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign valid_o = b_q.valid;
    assign data_o  = b_q.data;

endmodule

// File: rtl/strobe_ack_rx.sv
module strobe_ack_rx #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_dbl_i,
    input  logic              stb_n_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              ack_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i,
    input  logic              err_clr_i,
    output logic              proto_err_o
);
    logic fall_w, rise_w, capture_w, valid_w, dbl_w;

    strobe_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (stb_n_i),
        .fall_o  (fall_w),
        .rise_o  (rise_w)
    );

    strobe_rx_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_dbl_i (mode_dbl_i),
        .fall_i     (fall_w),
        .rise_i     (rise_w),
        .buf_full_i (valid_w),
        .err_clr_i  (err_clr_i),
        .capture_o  (capture_w),
        .ack_o      (ack_o),
        .dbl_o      (dbl_w),
        .err_o      (proto_err_o)
    );

    strobe_rx_obuf #(.DATA_W(DATA_W)) obuf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (capture_w),
        .data_i  (data_i),
        .ready_i (out_ready_i),
        .valid_o (valid_w),
        .data_o  (out_data_o)
    );

    assign out_valid_o = valid_w;

endmodule

// File: rtl/strobe_rx_chk.sv
module strobe_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              valid,
    input logic              ready,
    input logic [DATA_W-1:0] data,
    input logic              err,
    input logic              err_clr,
    input logic              dbl
);
    assert_ack_needs_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> !$past(valid));

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));

    assert_pop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> !valid);

    assert_single_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbl && $rose(valid)) |-> $rose(ack));

    assert_double_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl && $rose(valid)) |-> $fell(ack));

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err);

    assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(err_clr));

endmodule

bind strobe_ack_rx strobe_rx_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack_o),
    .valid   (out_valid_o),
    .ready   (out_ready_i),
    .data    (out_data_o),
    .err     (proto_err_o),
    .err_clr (err_clr_i),
    .dbl     (dbl_w)
);

// File: tb/strobe_ack_rx_tb_top.sv
`timescale 1ns/1ps
module strobe_ack_rx_tb_top;
    localparam int DATA_W = 8;
    localparam int NVEC   = 6;
    // {mode[11], ready hold cycles[10:8], byte[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{
        12'h0A5, 12'h83C, 12'h35A, 12'hBC3, 12'h100, 12'hFFF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_dbl = 1'b0;
    logic stb_n = 1'b1;
    logic [DATA_W-1:0] data = '0;
    logic ack, valid, ready = 1'b0, err_clr = 1'b0, err;
    logic [DATA_W-1:0] odata;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    strobe_ack_rx #(.DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_dbl_i(mode_dbl), .stb_n_i(stb_n),
        .data_i(data), .ack_o(ack), .out_valid_o(valid), .out_data_o(odata),
        .out_ready_i(ready), .err_clr_i(err_clr), .proto_err_o(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exchange(input logic dbl, input logic [7:0] b);
        mode_dbl = dbl;
        if (!dbl) begin
            data = b; stb_n = 1'b0;
            step(2); chk("R2 ack not early", ack, 0);
            step(1); chk("R2 ack", ack, 1); chk("R2 valid", valid, 1); chk("R2 data", odata, b);
            stb_n = 1'b1;
            step(2); chk("R3 ack held", ack, 1);
            step(1); chk("R3 ack drop", ack, 0);
        end else begin
            data = ~b; stb_n = 1'b0;
            step(2); chk("R4 ack not early", ack, 0);
            step(1); chk("R4 ack", ack, 1); chk("R4 valid low", valid, 0);
            data = b; stb_n = 1'b1;
            step(2); chk("R5 ack held", ack, 1); chk("R5 valid not early", valid, 0);
            step(1); chk("R5 ack drop", ack, 0); chk("R5 valid", valid, 1); chk("R5 data", odata, b);
        end
    endtask

    task automatic consume(input int hold, input logic [7:0] b);
        ready = 1'b0;
        for (int i = 0; i < hold; i++) begin
            step(1); chk("R6 valid held", valid, 1); chk("R6 data held", odata, b);
        end
        ready = 1'b1;
        step(1); chk("R6 valid after transfer", valid, 0);
        ready = 1'b0;
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 ack", ack, 0); chk("R1 valid", valid, 0); chk("R1 err", err, 0);

        for (int v = 0; v < NVEC; v++) begin
            exchange(VEC[v][11], VEC[v][7:0]);
            consume(int'(VEC[v][10:8]), VEC[v][7:0]);
        end

        // R7 single mode: request while buffer occupied
        exchange(1'b0, 8'h11);
        data = 8'h22; stb_n = 1'b0;
        step(6); chk("R7 ack held off", ack, 0); chk("R7 byte kept", odata, 8'h11);
        ready = 1'b1; step(1); ready = 1'b0;
        chk("R7 valid empty", valid, 0); chk("R7 ack not early", ack, 0);
        step(1); chk("R7 ack", ack, 1); chk("R7 valid", valid, 1); chk("R7 data", odata, 8'h22);
        stb_n = 1'b1; step(3); chk("R7 ack drop", ack, 0);
        consume(0, 8'h22);

        // R7 double mode
        exchange(1'b1, 8'h33);
        data = 8'h00; stb_n = 1'b0;
        step(6); chk("R7 dbl ack held off", ack, 0); chk("R7 dbl byte kept", odata, 8'h33);
        ready = 1'b1; step(1); ready = 1'b0;
        step(1); chk("R7 dbl ack", ack, 1); chk("R7 dbl valid low", valid, 0);
        data = 8'h44; stb_n = 1'b1;
        step(3); chk("R7 dbl valid", valid, 1); chk("R7 dbl data", odata, 8'h44);
        consume(1, 8'h44);

        // R8 strobe withdrawn while waiting
        exchange(1'b0, 8'h55);
        data = 8'h66; stb_n = 1'b0;
        step(4); chk("R8 ack low waiting", ack, 0);
        stb_n = 1'b1;
        step(2); chk("R8 err not early", err, 0);
        step(1); chk("R8 err", err, 1); chk("R8 ack", ack, 0);
        chk("R8 valid", valid, 1); chk("R8 byte kept", odata, 8'h55);
        consume(2, 8'h55);
        chk("R8 no byte latched", valid, 0);
        exchange(1'b0, 8'h77);
        consume(0, 8'h77);
        chk("R8 err sticky", err, 1);

        // R9 clear
        err_clr = 1'b1; step(1); err_clr = 1'b0;
        chk("R9 err cleared", err, 0);
        step(2); chk("R9 err stays clear", err, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule